// File: doc/BRIEF.md
# Systolic Multiply-Accumulate Cell

This block is one cell of a weight-stationary systolic array. It keeps a single signed weight in a register, multiplies it by the signed activation arriving from the left, adds the partial sum arriving from above, and registers that sum for the cell underneath. The activation is forwarded to the right neighbour through a register. A weight travels downward through another register, so a column of cells can be filled by shifting weights down it.

A load select picks between two modes. In load mode the cell captures a new weight, passes it downward and keeps its sum. In compute mode it produces one multiply-accumulate per enabled cycle. An active-low asynchronous reset and an active-high synchronous clear both zero every register. An enable freezes the whole cell when low.

Top module: `mac_cell`

## Requirements
- R1: While `rst_n` is low, `right_out`, `down_out` and `sum_out` are zero at once, without waiting for a clock edge, and the stored weight is zero.
- R2: On every clock edge with `en` high and `clr` low, `right_out` takes the value `act_in` had before that edge, in both modes.
- R3: In compute mode (`load` = 0) with `en` high, `sum_out` becomes `psum_in` plus the two's-complement product of `act_in` and the stored weight, one cycle later. The product is sign-extended to the sum width before the addition.
- R4: The addition in R3 wraps modulo 2^ACC_W; the cell raises no overflow indication.
- R5: `clr` high at a clock edge zeroes every register, including the stored weight, whatever `en` and `load` are.
- R6: With `en` low and `clr` low, every output and the stored weight hold their values, whatever the data and mode inputs do.
- R7: In load mode (`load` = 1) with `en` high, the stored weight and `down_out` both take `wgt_in` one cycle later, and `sum_out` holds.
- R8: In compute mode, the stored weight and `down_out` are unchanged, and the weight last loaded is used for every later product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear, active high |
| en | input | 1 | Cell enable; low freezes all registers |
| load | input | 1 | 1 = load weight, 0 = compute |
| act_in | input | DATA_W | Signed activation from the left |
| wgt_in | input | DATA_W | Weight from above, captured in load mode |
| psum_in | input | ACC_W | Partial sum from above |
| right_out | output | DATA_W | Registered activation to the right neighbour |
| down_out | output | DATA_W | Registered weight to the cell below |
| sum_out | output | ACC_W | Registered accumulated sum to the cell below |

## Verification
The stored weight has no port of its own. The bench therefore infers it from `down_out` and from later products. It loads a weight, then checks that a compute product uses that weight even after `wgt_in` has moved on. After a synchronous clear it runs a compute and expects exactly `psum_in` back, which shows that the weight was zeroed. The wrap case is reached by feeding a partial sum at the top of the signed range with a positive product, and a sum of all ones with a negative product. The two extreme negative operands check the sign extension.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic {
        MODE_COMPUTE = 1'b0,
        MODE_LOAD    = 1'b1
    } cell_mode_e;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int IN_W       = 8,
    parameter int OUT_W      = 32,
    parameter bit SIGNED_OPS = 1'b1
) (
    input  logic [IN_W-1:0]  a_i,
    input  logic [IN_W-1:0]  b_i,
    output logic [OUT_W-1:0] prod_o
);
    localparam int PROD_W = 2 * IN_W;
    localparam int EXT_W  = OUT_W - PROD_W;

    logic [PROD_W-1:0] prod_raw;

    generate
        if (SIGNED_OPS) begin : g_signed
            assign prod_raw = PROD_W'($signed(a_i) * $signed(b_i));
            assign prod_o   = {{EXT_W{prod_raw[PROD_W-1]}}, prod_raw};
        end else begin : g_unsigned
            assign prod_raw = PROD_W'(a_i * b_i);
            assign prod_o   = {{EXT_W{1'b0}}, prod_raw};
        end
    endgenerate

endmodule

// File: rtl/mac_acc.sv
module mac_acc #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    // Plain modular addition; carry out is discarded.
    assign sum_o = a_i + b_i;

endmodule

// File: rtl/mac_cell.sv
module mac_cell #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              load,
    input  logic [DATA_W-1:0] act_in,
    input  logic [DATA_W-1:0] wgt_in,
    input  logic [ACC_W-1:0]  psum_in,
    output logic [DATA_W-1:0] right_out,
    output logic [DATA_W-1:0] down_out,
    output logic [ACC_W-1:0]  sum_out
);
    import mac_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] right;
        logic [DATA_W-1:0] wgt;
        logic [DATA_W-1:0] down;
        logic [ACC_W-1:0]  sum;
    } cell_state_t;

    cell_state_t st_d, st_q;
    cell_mode_e  mode;
    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] mac_sum;

    assign mode = cell_mode_e'(load);

    mac_mult #(
        .IN_W      (DATA_W),
        .OUT_W     (ACC_W),
        .SIGNED_OPS(1'b1)
    ) u_mult (
        .a_i   (act_in),
        .b_i   (st_q.wgt),
        .prod_o(prod_ext)
    );

    mac_acc #(
        .W(ACC_W)
    ) u_acc (
        .a_i  (psum_in),
        .b_i  (prod_ext),
        .sum_o(mac_sum)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (en) begin
            st_d.right = act_in;
            if (mode == MODE_LOAD) begin
                st_d.wgt  = wgt_in;
                st_d.down = wgt_in;
            end else begin
                st_d.sum = mac_sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign right_out = st_q.right;
    assign down_out  = st_q.down;
    assign sum_out   = st_q.sum;

    // R2: activation forwarded with one cycle of latency
    p_fwd_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (right_out == $past(act_in)));

    // R5: synchronous clear zeroes all outputs
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (right_out == '0 && down_out == '0 && sum_out == '0));

    // R6: disabled cell holds everything
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> ($stable(right_out) && $stable(down_out) && $stable(sum_out)));

    // R7: load mode passes the weight down and keeps the sum
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load && !clr) |=> (down_out == $past(wgt_in) && $stable(sum_out)));

    // R8: compute mode leaves the weight path untouched
    p_keep_wgt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && !clr) |=> $stable(down_out));

endmodule

// File: tb/sim_mac_cell.sv
module sim_mac_cell;
    localparam int DW = 8;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          en = 1'b0;
    logic          load = 1'b0;
    logic [DW-1:0] act_in = '0;
    logic [DW-1:0] wgt_in = '0;
    logic [AW-1:0] psum_in = '0;
    logic [DW-1:0] right_out;
    logic [DW-1:0] down_out;
    logic [AW-1:0] sum_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mac_cell #(.DATA_W(DW), .ACC_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .load(load),
        .act_in(act_in), .wgt_in(wgt_in), .psum_in(psum_in),
        .right_out(right_out), .down_out(down_out), .sum_out(sum_out)
    );

    function automatic logic [AW-1:0] ref_mac(logic [AW-1:0] p, logic [DW-1:0] a, logic [DW-1:0] w);
        logic signed [2*DW-1:0] prod;
        logic [AW-1:0] ext;
        prod = $signed(a) * $signed(w);
        ext = {{(AW-2*DW){prod[2*DW-1]}}, prod};
        return p + ext;
    endfunction

    task automatic chk(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // apply inputs at negedge, then sample 1 ns after the next rising edge
    task automatic step(logic c, logic e, logic l, logic [DW-1:0] a, logic [DW-1:0] w, logic [AW-1:0] p);
        @(negedge clk);
        clr = c; en = e; load = l; act_in = a; wgt_in = w; psum_in = p;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 right", AW'(right_out), '0);
        chk("R1 down", AW'(down_out), '0);
        chk("R1 sum", sum_out, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_load();
        step(0, 1, 1, 8'd9, 8'd3, 32'd77);
        chk("R7 down", AW'(down_out), 32'd3);
        chk("R7 sum holds", sum_out, '0);
        chk("R2 right in load", AW'(right_out), 32'd9);
    endtask

    task automatic t_compute();
        step(0, 1, 0, 8'd5, 8'd99, 32'd100);
        chk("R3 pos", sum_out, ref_mac(32'd100, 8'd5, 8'd3));
        chk("R8 down holds", AW'(down_out), 32'd3);
        chk("R2 right", AW'(right_out), 32'd5);
        step(0, 1, 0, 8'hFC, 8'd50, 32'd10);
        chk("R3 neg act", sum_out, 32'hFFFF_FFFE);
        chk("R8 weight kept", AW'(down_out), 32'd3);
        step(0, 1, 1, 8'd0, 8'h80, 32'd0);
        step(0, 1, 0, 8'h80, 8'd1, 32'd0);
        chk("R3 extreme", sum_out, 32'd16384);
        step(0, 1, 0, 8'h7F, 8'd1, 32'd0);
        chk("R3 sign ext", sum_out, ref_mac(32'd0, 8'h7F, 8'h80));
    endtask

    task automatic t_wrap();
        step(0, 1, 1, 8'd0, 8'd3, 32'd0);
        step(0, 1, 0, 8'd1, 8'd0, 32'h7FFF_FFFF);
        chk("R4 wrap up", sum_out, 32'h8000_0002);
        step(0, 1, 0, 8'hFF, 8'd0, 32'hFFFF_FFFF);
        chk("R4 neg", sum_out, 32'hFFFF_FFFC);
        step(0, 1, 0, 8'd2, 8'd0, 32'hFFFF_FFFF);
        chk("R4 wrap zero", sum_out, 32'd5);
    endtask

    task automatic t_hold();
        logic [AW-1:0] s0;
        logic [DW-1:0] r0, d0;
        s0 = sum_out; r0 = right_out; d0 = down_out;
        step(0, 0, 1, 8'd44, 8'd66, 32'd123);
        step(0, 0, 0, 8'd45, 8'd67, 32'd124);
        chk("R6 sum", sum_out, s0);
        chk("R6 right", AW'(right_out), AW'(r0));
        chk("R6 down", AW'(down_out), AW'(d0));
        step(0, 1, 0, 8'd2, 8'd0, 32'd1);
        chk("R6 weight kept", sum_out, 32'd7);
    endtask

    task automatic t_clear();
        step(1, 0, 1, 8'd7, 8'd8, 32'd9);
        chk("R5 sum", sum_out, '0);
        chk("R5 right", AW'(right_out), '0);
        chk("R5 down", AW'(down_out), '0);
        step(0, 1, 0, 8'd100, 8'd5, 32'd555);
        chk("R5 weight cleared", sum_out, 32'd555);
    endtask

    task automatic t_async();
        step(0, 1, 1, 8'd11, 8'd12, 32'd0);
        step(0, 1, 0, 8'd2, 8'd0, 32'd1);
        chk("R7 reload", sum_out, 32'd25);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 async sum", sum_out, '0);
        chk("R1 async down", AW'(down_out), '0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 1, 0, 8'd6, 8'd0, 32'd40);
        chk("R1 weight zeroed", sum_out, 32'd40);
    endtask

    initial begin
        #1;
        t_reset();
        t_load();
        t_compute();
        t_wrap();
        t_hold();
        t_clear();
        t_async();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule